// File: doc/BRIEF.md
# Bit Test and Modify Execution Unit

This unit executes the four single-bit operations of a general-purpose integer core: test, set, clear and flip. Each operation is given an operand size of 16, 32 or 64 bits and a bit offset. The offset comes either from a 64-bit register value, read as signed, or from an 8-bit immediate, read as unsigned. The addressed bit is returned as the carry flag. The set, clear and flip operations also produce a modified operand. All four operations use the same single-hot mask, built from the bit position.

With a register destination, the result appears one cycle after `start` on the writeback outputs. With a memory destination, a small sequencer works out a word address. It shifts the offset right arithmetically by log2 of the operand width, scales the result by the operand size in bytes and adds it to a base address. The sequencer then issues a load. For the modifying operations it next issues a store of the changed word to the same address. For immediate-offset instructions, the ModRM reg field chooses the operation, and reg values 0 to 3 raise an undefined-opcode fault.

Top module: `bitop_unit`

## Requirements
- R1: Every operation that completes without a fault reports on `cf` the value of the addressed bit in the operand before modification, valid while `done` is high.
- R2: The test operation (`op_sel`=0) never writes. A register form completes with `wb_en`=0. A memory form completes in the cycle after `ld_ack` and issues no `st_req`.
- R3: The set operation (`op_sel`=1) returns the operand ORed with a one at the bit position.
- R4: The clear operation (`op_sel`=2) returns the operand ANDed with a mask that has a zero at the bit position and ones everywhere else.
- R5: The flip operation (`op_sel`=3) returns the operand XORed with a one at the bit position.
- R6: When `use_imm`=1, `modrm_reg` values 4, 5, 6 and 7 select test, set, clear and flip. Values 0 to 3 complete one cycle later with `done`=1 and `ud_fault`=1, with no writeback and no load.
- R7: The bit position is the offset modulo the operand width: its low 4, 5 or 6 bits for `size_sel` 0 (16-bit), 1 (32-bit) and 2 or 3 (64-bit). The immediate offset is zero-extended.
- R8: For a memory operand, the address is `mem_base` + (offset >>> log2(width)) × (width/8), taken modulo 2^ADDR_W, so a negative offset addresses words below the base.
- R9: A modifying memory operation first loads, then stores the modified loaded word to the address it loaded from. The store data and `cf` are both computed from `ld_data`.
- R10: `busy` is high from the cycle after a memory `start` until the store is acknowledged, or until the load is acknowledged for a test. `start` is ignored while `busy` is high.
- R11: For 16-bit and 32-bit operands, the bits of the result above the operand size equal the input operand.
- R12: A register-form operation raises `done`, and `wb_en` when it modifies, for exactly one cycle, one cycle after `start`. A memory operation raises `done` one cycle after its final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| is_mem | input | 1 | Destination is in memory |
| use_imm | input | 1 | Offset from immediate; op from ModRM reg |
| op_sel | input | 2 | Op for register-offset forms: 0 test, 1 set, 2 clear, 3 flip |
| modrm_reg | input | 3 | ModRM reg field for immediate forms |
| size_sel | input | 2 | 0: 16-bit, 1: 32-bit, 2/3: 64-bit |
| dest_val | input | 64 | Register destination operand |
| off_reg | input | 64 | Signed register bit offset |
| off_imm | input | 8 | Unsigned immediate bit offset |
| mem_base | input | ADDR_W | Memory operand base address |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Operation complete (one cycle) |
| cf | output | 1 | Addressed bit, valid with done |
| ud_fault | output | 1 | Undefined-opcode fault, with done |
| wb_en | output | 1 | Register writeback strobe |
| wb_val | output | 64 | Register writeback value |
| ld_req | output | 1 | Load request, held until ld_ack |
| ld_addr | output | ADDR_W | Load address |
| ld_ack | input | 1 | Load accepted, data valid |
| ld_data | input | 64 | Loaded word |
| st_req | output | 1 | Store request, held until st_ack |
| st_addr | output | ADDR_W | Store address |
| st_data | output | 64 | Store data |
| st_ack | input | 1 | Store accepted |

## Verification
The assertions assume that the memory side acknowledges only a request that is pending: `ld_ack` only while `ld_req` is high, and `st_ack` only while `st_req` is high. Under that assumption they check request hold, store-to-load address equality and that the strobes are mutually consistent. The bench drives every acknowledge in a cycle where it has first seen the matching request at the ports. It keeps each acknowledge high for one cycle, and it holds `st_ack` low for an extra cycle in one case to test the hold behaviour. The only `start` it raises during a sequence is the deliberate one that tests R10.

// File: rtl/bitop_pkg.sv
// Shared types for the bit test and modify unit.
package bitop_pkg;
    localparam int WORD_W = 64;
    localparam int POS_W  = 6;

    typedef enum logic [1:0] {
        OP_TEST = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_FLIP = 2'd3
    } bop_e;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_64B = 2'd3
    } bsz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2
    } bseq_e;
endpackage

// File: rtl/bitop_decode.sv
// Operation decoder. For immediate-offset forms the ModRM reg field picks the
// op (reg[2] must be set, reg[1:0] gives the op); otherwise op_sel is used.
// Assumes: purely combinational, consumed only when start is sampled.
module bitop_decode
    import bitop_pkg::*;
(
    input  logic       use_imm,
    input  logic [1:0] op_sel,
    input  logic [2:0] modrm_reg,
    output bop_e       op,
    output logic       ud
);
    // Select the op source and flag undefined reg encodings.
    always_comb begin
        if (use_imm) begin
            op = bop_e'(modrm_reg[1:0]);
            ud = ~modrm_reg[2];
        end else begin
            op = bop_e'(op_sel);
            ud = 1'b0;
        end
    end
endmodule

// File: rtl/bitop_offset.sv
// Offset splitter. Turns the bit offset into a bit position inside the operand
// and, for memory forms, a signed byte displacement added to the base.
// Assumes: ADDR_W <= 64; register offsets are signed, immediates unsigned.
module bitop_offset
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              use_imm,
    input  logic [7:0]        off_imm,
    input  logic [WORD_W-1:0] off_reg,
    input  bsz_e              size,
    input  logic [ADDR_W-1:0] base,
    output logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] addr
);
    logic signed [WORD_W-1:0] offs;
    logic signed [WORD_W-1:0] word_idx;
    logic signed [WORD_W-1:0] disp;

    // Pick the offset source, zero-extending the immediate.
    always_comb begin
        if (use_imm) offs = {{(WORD_W-8){1'b0}}, off_imm};
        else         offs = off_reg;
    end

    // Split per operand width: position = offset mod width, word = offset >>> log2(width).
    always_comb begin
        unique case (size)
            SZ_16: begin
                pos      = {2'b00, offs[3:0]};
                word_idx = offs >>> 4;
                disp     = word_idx <<< 1;
            end
            SZ_32: begin
                pos      = {1'b0, offs[4:0]};
                word_idx = offs >>> 5;
                disp     = word_idx <<< 2;
            end
            default: begin
                pos      = offs[5:0];
                word_idx = offs >>> 6;
                disp     = word_idx <<< 3;
            end
        endcase
    end

    // Form the word address with wrap-around at the address width.
    always_comb begin
        addr = base + disp[ADDR_W-1:0];
    end
endmodule

// File: rtl/bitop_alu.sv
// Bit operation datapath. Builds one single-hot mask from the bit position and
// uses it for test, set, clear and flip. Bits above the position's range are
// untouched, so narrow operands keep their upper bits.
// Assumes: pos is already reduced modulo the operand width.
module bitop_alu
    import bitop_pkg::*;
(
    input  bop_e              op,
    input  logic [POS_W-1:0]  pos,
    input  logic [WORD_W-1:0] operand,
    output logic              bit_val,
    output logic [WORD_W-1:0] result
);
    logic [WORD_W-1:0] onehot;

    // One comparator per bit forms the single-hot mask.
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign onehot[i] = (pos == POS_W'(i));
    end

    // Extract the addressed bit.
    always_comb begin
        bit_val = |(operand & onehot);
    end

    // Apply the selected modification.
    always_comb begin
        unique case (op)
            OP_SET:  result = operand | onehot;
            OP_CLR:  result = operand & ~onehot;
            OP_FLIP: result = operand ^ onehot;
            default: result = operand;
        endcase
    end
endmodule

// File: rtl/bitop_seq.sv
// Sequencer. Completes register forms in one cycle. Runs memory forms as
// load then (for modifying ops) store to the same address.
// Assumes: ld_ack/st_ack arrive only while the matching request is pending;
// alu_* reflect the live inputs when idle and the latched op/pos on ld_data
// when busy (the top muxes them from op_q/pos_q).
module bitop_seq
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_mem,
    input  logic              ud,
    input  bop_e              op_in,
    input  logic [POS_W-1:0]  pos_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              alu_bit,
    input  logic [WORD_W-1:0] alu_res,
    input  logic              ld_ack,
    input  logic              st_ack,
    output logic              busy,
    output bop_e              op_q,
    output logic [POS_W-1:0]  pos_q,
    output logic              done,
    output logic              cf,
    output logic              ud_fault,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_val,
    output logic              ld_req,
    output logic              st_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] st_data
);
    bseq_e             state;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] st_data_q;

    // State, completion strobes and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= OP_TEST;
            pos_q     <= '0;
            addr_q    <= '0;
            st_data_q <= '0;
            done      <= 1'b0;
            cf        <= 1'b0;
            ud_fault  <= 1'b0;
            wb_en     <= 1'b0;
            wb_val    <= '0;
        end else begin
            done     <= 1'b0;
            wb_en    <= 1'b0;
            ud_fault <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (ud) begin
                            done     <= 1'b1;
                            ud_fault <= 1'b1;
                            cf       <= 1'b0;
                        end else if (is_mem) begin
                            op_q   <= op_in;
                            pos_q  <= pos_in;
                            addr_q <= addr_in;
                            state  <= ST_LOAD;
                        end else begin
                            done   <= 1'b1;
                            cf     <= alu_bit;
                            wb_en  <= (op_in != OP_TEST);
                            wb_val <= alu_res;
                        end
                    end
                end
                ST_LOAD: begin
                    if (ld_ack) begin
                        cf <= alu_bit;
                        if (op_q == OP_TEST) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            st_data_q <= alu_res;
                            state     <= ST_STORE;
                        end
                    end
                end
                ST_STORE: begin
                    if (st_ack) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request and status outputs decoded from the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        ld_req   = (state == ST_LOAD);
        st_req   = (state == ST_STORE);
        mem_addr = addr_q;
        st_data  = st_data_q;
    end
endmodule

// File: rtl/bitop_unit.sv
// Top of the bit test and modify unit. Decodes the op, splits the offset,
// runs the shared mask datapath and sequences memory operands.
// Assumes: one operation at a time; memory acks follow their requests.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_mem,
    input  logic              use_imm,
    input  logic [1:0]        op_sel,
    input  logic [2:0]        modrm_reg,
    input  logic [1:0]        size_sel,
    input  logic [63:0]       dest_val,
    input  logic [63:0]       off_reg,
    input  logic [7:0]        off_imm,
    input  logic [ADDR_W-1:0] mem_base,
    output logic              busy,
    output logic              done,
    output logic              cf,
    output logic              ud_fault,
    output logic              wb_en,
    output logic [63:0]       wb_val,
    output logic              ld_req,
    output logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_ack,
    input  logic [63:0]       ld_data,
    output logic              st_req,
    output logic [ADDR_W-1:0] st_addr,
    output logic [63:0]       st_data,
    input  logic              st_ack
);
    bop_e              op_live;
    bop_e              op_q;
    bop_e              alu_op;
    logic              ud_live;
    logic [POS_W-1:0]  pos_live;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  alu_pos;
    logic [ADDR_W-1:0] addr_live;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] alu_operand;
    logic [WORD_W-1:0] alu_res;
    logic              alu_bit;

    bitop_decode u_dec (
        .use_imm   (use_imm),
        .op_sel    (op_sel),
        .modrm_reg (modrm_reg),
        .op        (op_live),
        .ud        (ud_live)
    );

    bitop_offset #(.ADDR_W(ADDR_W)) u_off (
        .use_imm (use_imm),
        .off_imm (off_imm),
        .off_reg (off_reg),
        .size    (bsz_e'(size_sel)),
        .base    (mem_base),
        .pos     (pos_live),
        .addr    (addr_live)
    );

    // Feed the datapath: live register operand when idle, loaded word when busy.
    always_comb begin
        if (busy) begin
            alu_op      = op_q;
            alu_pos     = pos_q;
            alu_operand = ld_data;
        end else begin
            alu_op      = op_live;
            alu_pos     = pos_live;
            alu_operand = dest_val;
        end
    end

    bitop_alu u_alu (
        .op      (alu_op),
        .pos     (alu_pos),
        .operand (alu_operand),
        .bit_val (alu_bit),
        .result  (alu_res)
    );

    bitop_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_mem   (is_mem),
        .ud       (ud_live),
        .op_in    (op_live),
        .pos_in   (pos_live),
        .addr_in  (addr_live),
        .alu_bit  (alu_bit),
        .alu_res  (alu_res),
        .ld_ack   (ld_ack),
        .st_ack   (st_ack),
        .busy     (busy),
        .op_q     (op_q),
        .pos_q    (pos_q),
        .done     (done),
        .cf       (cf),
        .ud_fault (ud_fault),
        .wb_en    (wb_en),
        .wb_val   (wb_val),
        .ld_req   (ld_req),
        .st_req   (st_req),
        .mem_addr (mem_addr),
        .st_data  (st_data)
    );

    // Loads and stores of one sequence share the captured address.
    always_comb begin
        ld_addr = mem_addr;
        st_addr = mem_addr;
    end
endmodule

// File: rtl/bitop_unit_chk.sv
// Port-level checker for bitop_unit, attached by bind below.
// Assumes: acks only arrive while the matching request is pending.
module bitop_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ud_fault,
    input logic              wb_en,
    input logic              ld_req,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              ld_ack,
    input logic              st_req,
    input logic [ADDR_W-1:0] st_addr,
    input logic              st_ack
);
    logic [ADDR_W-1:0] seen_addr;

    // Record the address of each accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_addr <= '0;
        else if (ld_req && ld_ack) seen_addr <= ld_addr;
    end

    a_r10_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req || st_req) |-> busy);
    a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_req && st_req));
    a_r9_store_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (st_addr == seen_addr));
    a_r9_load_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_ack) |=> (ld_req && $stable(ld_addr)));
    a_r10_store_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> st_req);
    a_r6_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> (done && !wb_en));
    a_r12_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !ld_ack && !st_ack) |=> busy);
endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ud_fault (ud_fault),
    .wb_en    (wb_en),
    .ld_req   (ld_req),
    .ld_addr  (ld_addr),
    .ld_ack   (ld_ack),
    .st_req   (st_req),
    .st_addr  (st_addr),
    .st_ack   (st_ack)
);

// File: tb/bitop_unit_test.sv
// Directed bench for bitop_unit: one task per scenario.
module bitop_unit_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_mem = 1'b0;
    logic          use_imm = 1'b0;
    logic [1:0]    op_sel = '0;
    logic [2:0]    modrm_reg = '0;
    logic [1:0]    size_sel = '0;
    logic [63:0]   dest_val = '0;
    logic [63:0]   off_reg = '0;
    logic [7:0]    off_imm = '0;
    logic [AW-1:0] mem_base = '0;
    logic          busy, done, cf, ud_fault, wb_en, ld_req, st_req;
    logic [63:0]   wb_val, st_data;
    logic [AW-1:0] ld_addr, st_addr;
    logic          ld_ack = 1'b0;
    logic          st_ack = 1'b0;
    logic [63:0]   ld_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bitop_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_mem(is_mem),
        .use_imm(use_imm), .op_sel(op_sel), .modrm_reg(modrm_reg),
        .size_sel(size_sel), .dest_val(dest_val), .off_reg(off_reg),
        .off_imm(off_imm), .mem_base(mem_base), .busy(busy), .done(done),
        .cf(cf), .ud_fault(ud_fault), .wb_en(wb_en), .wb_val(wb_val),
        .ld_req(ld_req), .ld_addr(ld_addr), .ld_ack(ld_ack), .ld_data(ld_data),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_ack(st_ack)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a register-form op and check the result one cycle later.
    task automatic reg_op(input string tag, input logic imm, input logic [1:0] ops,
                          input logic [2:0] mr, input logic [1:0] sz,
                          input logic [63:0] dv, input logic [63:0] ofr,
                          input logic [7:0] ofi, input logic exp_ud,
                          input logic exp_cf, input logic exp_wb,
                          input logic [63:0] exp_val);
        @(negedge clk);
        is_mem = 1'b0; use_imm = imm; op_sel = ops; modrm_reg = mr;
        size_sel = sz; dest_val = dv; off_reg = ofr; off_imm = ofi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R12 done"}, 64'(done), 64'd1);
        chk({tag, " R6 ud"}, 64'(ud_fault), 64'(exp_ud));
        chk({tag, " R2 wb_en"}, 64'(wb_en), 64'(exp_wb));
        if (!exp_ud) chk({tag, " R1 cf"}, 64'(cf), 64'(exp_cf));
        if (exp_wb) chk({tag, " wb_val"}, wb_val, exp_val);
        @(negedge clk);
        chk({tag, " R12 one-cycle"}, 64'(done | wb_en), 64'd0);
    endtask

    // Drive a memory-form op through load and optional store.
    task automatic mem_op(input string tag, input logic imm, input logic [1:0] ops,
                          input logic [2:0] mr, input logic [1:0] sz,
                          input logic [63:0] ofr, input logic [7:0] ofi,
                          input logic [AW-1:0] base, input logic [AW-1:0] exp_addr,
                          input logic [63:0] ldv, input logic exp_cf,
                          input logic exp_store, input logic [63:0] exp_st,
                          input bit poke_busy);
        @(negedge clk);
        is_mem = 1'b1; use_imm = imm; op_sel = ops; modrm_reg = mr;
        size_sel = sz; off_reg = ofr; off_imm = ofi; mem_base = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R10 busy"}, 64'(busy), 64'd1);
        chk({tag, " R9 ld_req"}, 64'(ld_req), 64'd1);
        chk({tag, " R8 ld_addr"}, 64'(ld_addr), 64'(exp_addr));
        if (poke_busy) begin
            is_mem = 1'b0; use_imm = 1'b0; op_sel = 2'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk({tag, " R10 start ignored done"}, 64'(done), 64'd0);
            chk({tag, " R10 start ignored ld"}, 64'(ld_req), 64'd1);
        end
        ld_data = ldv; ld_ack = 1'b1;
        @(negedge clk);
        ld_ack = 1'b0;
        if (!exp_store) begin
            chk({tag, " R2 done after load"}, 64'(done), 64'd1);
            chk({tag, " R1 cf"}, 64'(cf), 64'(exp_cf));
            chk({tag, " R2 no store"}, 64'(st_req), 64'd0);
            chk({tag, " R10 idle"}, 64'(busy), 64'd0);
        end else begin
            chk({tag, " R9 st_req"}, 64'(st_req), 64'd1);
            chk({tag, " R9 st_addr"}, 64'(st_addr), 64'(exp_addr));
            chk({tag, " R9 st_data"}, st_data, exp_st);
            if (poke_busy) begin
                @(negedge clk);
                chk({tag, " R10 store held"}, 64'(st_req & busy), 64'd1);
            end
            st_ack = 1'b1;
            @(negedge clk);
            st_ack = 1'b0;
            chk({tag, " R12 done"}, 64'(done), 64'd1);
            chk({tag, " R1 cf"}, 64'(cf), 64'(exp_cf));
            chk({tag, " R10 idle"}, 64'(busy), 64'd0);
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("reset done", 64'(done), 64'd0);
        chk("reset R10 busy", 64'(busy), 64'd0);
        chk("reset reqs", 64'({ld_req, st_req, wb_en}), 64'd0);
    endtask

    task automatic t_reg_forms;
        reg_op("R3 set64", 1'b0, 2'd1, 3'd0, 2'd2, 64'h0, 64'd63, 8'd0,
               1'b0, 1'b0, 1'b1, 64'h8000_0000_0000_0000);
        reg_op("R4 R7 R11 clr32", 1'b0, 2'd2, 3'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF,
               64'd37, 8'd0, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFDF);
        reg_op("R5 R11 flip16", 1'b0, 2'd3, 3'd0, 2'd0, 64'h1234_5678_9ABC_DEF0,
               64'd19, 8'd0, 1'b0, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF8);
        reg_op("R2 test64", 1'b0, 2'd0, 3'd0, 2'd2, 64'h10, 64'd4, 8'd0,
               1'b0, 1'b1, 1'b0, 64'h0);
    endtask

    task automatic t_imm_decode;
        reg_op("R6 R7 imm set", 1'b1, 2'd0, 3'd5, 2'd2, 64'h0, 64'h0, 8'h41,
               1'b0, 1'b0, 1'b1, 64'h2);
        reg_op("R6 imm flip", 1'b1, 2'd0, 3'd7, 2'd2, 64'hFF, 64'h0, 8'd3,
               1'b0, 1'b1, 1'b1, 64'hF7);
        reg_op("R6 imm clr", 1'b1, 2'd3, 3'd6, 2'd1, 64'hF, 64'h0, 8'd0,
               1'b0, 1'b1, 1'b1, 64'hE);
        reg_op("R6 ud reg2", 1'b1, 2'd1, 3'd2, 2'd2, 64'h0, 64'h0, 8'd0,
               1'b1, 1'b0, 1'b0, 64'h0);
        // Memory form with undefined reg: fault and no load.
        @(negedge clk);
        is_mem = 1'b1; use_imm = 1'b1; modrm_reg = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 mem ud fault", 64'(ud_fault & done), 64'd1);
        chk("R6 mem ud no load", 64'({ld_req, busy}), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_mem_forms;
        mem_op("R8 R9 R11 set32 neg", 1'b0, 2'd1, 3'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF,
               8'd0, 32'h1000, 32'h0FFC, 64'hAAAA_AAAA_0000_0000, 1'b0, 1'b1,
               64'hAAAA_AAAA_8000_0000, 1'b0);
        mem_op("R2 R8 test64", 1'b0, 2'd0, 3'd0, 2'd2, 64'd130, 8'd0,
               32'h2000, 32'h2010, 64'h4, 1'b1, 1'b0, 64'h0, 1'b0);
        mem_op("R5 R10 flip16 imm", 1'b1, 2'd0, 3'd7, 2'd0, 64'h0, 8'h25,
               32'h3000, 32'h3004, 64'hFFFF, 1'b1, 1'b1, 64'hFFDF, 1'b1);
        mem_op("R4 R8 clr16 neg", 1'b0, 2'd2, 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFEF,
               8'd0, 32'h0100, 32'h00FC, 64'h8000, 1'b1, 1'b1, 64'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_forms();
        t_imm_decode();
        t_mem_forms();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule